// File: doc/BRIEF.md
# DMA Channel Grant Arbiter

This block decides which of several DMA channels may use the shared bus next. Each channel raises its request line. When the bus is free, the arbiter picks one requester and drives a one-hot grant. It also raises a bus-request output that stalls the CPU. The grant stays with that channel until the channel reports, through `xfer_done`, that its unit or its block has finished. The arbiter then releases the bus and arbitrates again among the requests still pending.

Three run-time controls shape the choice:

- **`rr_en`** picks the priority scheme. With it low, priority is fixed. With it high, priority rotates so that the most recently granted channel goes to the back of the line.
- **`rmw_hold_en`** holds off new grants while the CPU reports a read-modify-write in progress.
- **`nmi_abort_en`** lets a non-maskable interrupt cut the current grant short. The granted channel receives a one-cycle abort pulse, and new grants stay blocked until the interrupt handler signals completion on `nmi_done`.

Top module: `dma_grant_arb`

## Requirements
- R1: After reset `gnt`, `bus_req` and `abort_pulse` are all zero, and the rotating pointer is set so that the first rotating arbitration searches upward from channel 0.
- R2: With `rr_en` low, the lowest-numbered requesting channel is granted.
- R3: With `rr_en` high, the search starts at the channel after the one granted last and wraps from the top index to channel 0. A lone requester is granted even if it was the last one served. A mode change applies from the next arbitration.
- R4: A grant is issued on the clock edge that samples a pending request while no grant is held. `gnt` has at most one bit set (bit i = channel i), and `bus_req` is high exactly while a grant is held.
- R5: A held grant is unchanged by changes in `req` until `xfer_done` is sampled high. On that edge the grant is removed. A new arbitration takes place on the following edge at the earliest.
- R6: With `rmw_hold_en` high, no new grant is issued on any edge that samples `cpu_rmw` high. The grant is issued on the first edge after `cpu_rmw` falls.
- R7: With `rmw_hold_en` low, `cpu_rmw` has no effect on grants.
- R8: With `nmi_abort_en` high, an edge that samples `nmi_evt` high removes any held grant. The same edge drives `abort_pulse` to that grant's one-hot value for exactly one cycle.
- R9: After such an NMI, no grant is issued until `nmi_done` has been sampled high. The earliest new grant comes on the edge after that.
- R10: With `nmi_abort_en` low, `nmi_evt` neither removes a grant, nor raises `abort_pulse`, nor blocks new grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_en | input | 1 | 1 = rotating priority, 0 = fixed priority |
| nmi_abort_en | input | 1 | Lets an NMI abort the current grant |
| rmw_hold_en | input | 1 | Holds off grants during CPU read-modify-write |
| req | input | NCH | Per-channel transfer request |
| xfer_done | input | 1 | Granted channel has finished its unit or block |
| cpu_rmw | input | 1 | CPU read-modify-write in progress |
| nmi_evt | input | 1 | NMI event |
| nmi_done | input | 1 | NMI processing finished |
| gnt | output | NCH | One-hot grant |
| bus_req | output | 1 | Bus request that stalls the CPU |
| abort_pulse | output | NCH | One-cycle abort to the channel that held the grant |

## Verification
The hardest situation to reach is the rotating pointer wrapping past the top channel while several channels request at once. Before the check can show that the search restarts at channel 0, an earlier grant must first have moved the pointer onto channel 7. The stimulus table chains grants so that each entry relies on the pointer left by the one before. It mixes fixed and rotating entries, which also shows that grants made in fixed mode move the pointer too.

The NMI checks need a grant held at the moment the event arrives, with requests still pending. Only then does a missing block show up as a stray regrant.

// File: rtl/dma_grant_arb.sv
module dma_grant_arb #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rr_en,
  input  logic           nmi_abort_en,
  input  logic           rmw_hold_en,
  input  logic [NCH-1:0] req,
  input  logic           xfer_done,
  input  logic           cpu_rmw,
  input  logic           nmi_evt,
  input  logic           nmi_done,
  output logic [NCH-1:0] gnt,
  output logic           bus_req,
  output logic [NCH-1:0] abort_pulse
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW-1:0] TOP = IW'(NCH - 1);

  logic [NCH-1:0] gnt_q, abort_q;
  logic [IW-1:0]  last_q, base, win_idx;
  logic           win_ok, nmi_blk_q, nmi_hit, hold, idle, issue;

  assign nmi_hit = nmi_abort_en & nmi_evt;
  assign hold    = rmw_hold_en & cpu_rmw;
  assign idle    = (gnt_q == '0);
  assign base    = rr_en ? ((last_q == TOP) ? '0 : last_q + 1'b1) : '0;
  assign issue   = idle & win_ok & ~hold & ~nmi_blk_q & ~nmi_hit;

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    for (int k = 0; k < NCH; k++) begin
      logic [IW:0] idx;
      idx = {1'b0, base} + (IW+1)'(k);
      if (idx >= (IW+1)'(NCH)) idx = idx - (IW+1)'(NCH);
      if (!win_ok && req[idx[IW-1:0]]) begin
        win_ok  = 1'b1;
        win_idx = idx[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      abort_q   <= '0;
      last_q    <= TOP;
      nmi_blk_q <= 1'b0;
    end else begin
      abort_q <= '0;
      if (nmi_hit) begin
        abort_q   <= gnt_q;
        gnt_q     <= '0;
        nmi_blk_q <= 1'b1;
      end else begin
        if (nmi_done) nmi_blk_q <= 1'b0;
        if (!idle && xfer_done) gnt_q <= '0;
        else if (issue) begin
          gnt_q  <= NCH'(1) << win_idx;
          last_q <= win_idx;
        end
      end
    end
  end

  assign gnt         = gnt_q;
  assign bus_req     = |gnt_q;
  assign abort_pulse = abort_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (($past(req) & gnt) == gnt)); // R4
  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !xfer_done && !nmi_hit) |=> (gnt == $past(gnt))); // R5
  AST_RMW_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && rmw_hold_en && cpu_rmw) |=> !bus_req); // R6
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse != '0) |=> (abort_pulse == '0)); // R8
  AST_ABORT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse != '0) |-> ($past(gnt) == abort_pulse && !bus_req)); // R8
  AST_NMI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_blk_q && !nmi_done) |=> !bus_req); // R9
  AST_NMI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_abort_en |=> (abort_pulse == '0)); // R10
endmodule

// File: tb/tb_dma_grant_arb.sv
module tb_dma_grant_arb;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0;
  logic rr_en = 0, nmi_abort_en = 0, rmw_hold_en = 0;
  logic [NCH-1:0] req = '0;
  logic xfer_done = 0, cpu_rmw = 0, nmi_evt = 0, nmi_done = 0;
  logic [NCH-1:0] gnt, abort_pulse;
  logic bus_req;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_grant_arb #(.NCH(NCH)) dut (.*);

  // {rr_en, req, expected one-hot grant}, applied in order from reset
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'hFF, 8'h01}, {1'b0, 8'hA0, 8'h20}, {1'b1, 8'hFF, 8'h40},
    {1'b1, 8'hFF, 8'h80}, {1'b1, 8'hFF, 8'h01}, {1'b1, 8'h05, 8'h04},
    {1'b1, 8'h05, 8'h01}, {1'b1, 8'h81, 8'h80}, {1'b0, 8'h81, 8'h01},
    {1'b1, 8'h01, 8'h01}, {1'b0, 8'h80, 8'h80}, {1'b1, 8'h80, 8'h80}};

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req = '0; xfer_done = 0; cpu_rmw = 0; nmi_evt = 0; nmi_done = 0;
    tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic finish_grant();
    xfer_done = 1; req = '0; tick(); xfer_done = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 reset outputs", {gnt, abort_pulse, 7'b0, bus_req}, 32'h0);
    // R1: first rotating arbitration starts at channel 0
    rr_en = 1; req = 8'h86; tick();
    chk("R1 rr start", gnt, 8'h02);
    finish_grant();
    do_reset();

    // R2 R3 R11-style mode changes: table walk
    foreach (VEC[i]) begin
      rr_en = VEC[i][16]; req = VEC[i][15:8]; tick();
      chk(VEC[i][16] ? "R3 rotating pick" : "R2 fixed pick", gnt, VEC[i][7:0]);
      chk("R4 bus_req with grant", bus_req, 1'b1);
      finish_grant();
      chk("R5 release after done", gnt, 8'h00);
    end

    // R5: grant held while req changes
    rr_en = 0; req = 8'h10; tick();
    req = 8'h01; tick(); tick();
    chk("R5 held grant", gnt, 8'h10);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R5 gap cycle", gnt, 8'h00);
    tick();
    chk("R5 rearbitrate", gnt, 8'h01);
    finish_grant();

    // R6: hold-off during CPU read-modify-write
    rmw_hold_en = 1; cpu_rmw = 1; req = 8'h04; tick(); tick(); tick();
    chk("R6 held off", {bus_req, gnt}, 9'h000);
    cpu_rmw = 0; tick();
    chk("R6 grant after rmw", gnt, 8'h04);
    finish_grant();
    // R7: hold-off disabled
    rmw_hold_en = 0; cpu_rmw = 1; req = 8'h08; tick();
    chk("R7 rmw ignored", gnt, 8'h08);
    cpu_rmw = 0; finish_grant();

    // R8 R9: NMI abort
    nmi_abort_en = 1; req = 8'h28; tick();
    chk("R8 pre-nmi grant", gnt, 8'h08);
    nmi_evt = 1; tick(); nmi_evt = 0;
    chk("R8 abort pulse", abort_pulse, 8'h08);
    chk("R8 grant dropped", gnt, 8'h00);
    tick();
    chk("R8 pulse one cycle", abort_pulse, 8'h00);
    tick(); tick();
    chk("R9 blocked", gnt, 8'h00);
    nmi_done = 1; tick(); nmi_done = 0;
    chk("R9 still blocked at done edge", gnt, 8'h00);
    tick();
    chk("R9 grant after done", gnt, 8'h08);
    finish_grant();

    // R10: NMI abort disabled
    nmi_abort_en = 0; req = 8'h02; tick();
    nmi_evt = 1; tick(); nmi_evt = 0;
    chk("R10 grant kept", gnt, 8'h02);
    chk("R10 no abort", abort_pulse, 8'h00);
    finish_grant();
    nmi_evt = 1; req = 8'h40; tick(); nmi_evt = 0;
    chk("R10 no block", gnt, 8'h40);
    finish_grant();

    summary();
  end
endmodule